// File: doc/BRIEF.md
# Watchdog and Memory Control Register

This block is one special-function register of an 8-bit microcontroller. It joins a prescaled watchdog timer with a few control bits that route data-pointer memory accesses. Software reaches it over a byte-wide register bus. The bus has an address, a write strobe, write data and combinational read data. The same bus also reaches a one-bit power-off flag, which sits in a separate power-control register.

The watchdog counts single-cycle base ticks. Its period is 16 ticks scaled by a power of two that a 3-bit prescaler field selects, so it spans 16 to 2048 ticks. When the count reaches the period, the block raises a one-clock reset request and starts again from zero. Software restarts the count by writing 1 to the kick bit. That bit never holds a value: a read at its position returns the EEPROM ready flag. The other bits drive three outputs: the data-pointer bank select, the on-chip EEPROM access enable and the EEPROM write enable.

Top module: `wdt_memctl_sfr`

## Requirements
- R1: Control register layout, bit 7 to bit 0: prescaler[2:0], EEPROM write enable, EEPROM access enable, bank select, kick/ready, watchdog enable. After reset the control register reads 0x02 when EEPROM programming is not busy. All three routing outputs are low and no reset request is raised.
- R2: A write to address 0x96 stores bits 4, 3 and 2. These drive ee_wr_en_o, ee_en_o and dp_sel_o on the cycle after the write. A write to any other address leaves them unchanged.
- R3: Bit 1 of a read at 0x96 is 1 when ee_busy_i is low and 0 when it is high. It never returns a value written to it.
- R4: Writing 1 to bit 1 produces a one-cycle kick, and that kick clears the watchdog count. The next reset request comes after period+1 clock edges, counted from the write edge, when tick_i is high every cycle.
- R5: The period is 16 << prescaler ticks. The counter advances only on cycles with tick_i high. The reset request appears exactly one period of ticks after counting starts.
- R6: The reset request wdt_rst_o is exactly one cycle wide. Counting then restarts from zero, so the next request follows one full period later.
- R7: While bit 0 (watchdog enable) is 0, the count is held at zero and no reset request is raised. After it is set again, counting starts afresh.
- R8: A write that changes the prescaler clears the count. With ticks every cycle, the next request comes after new period+1 edges, counted from the write edge.
- R9: If a kick and the final tick of a period fall on the same clock edge, the kick wins. No request is raised, and the next one comes a full period later.
- R10: The power-off flag is bit 4 of address 0x87, and the other bits of that address read 0. The flag is set by por_i. Software sets or clears it by writing bit 4, and rst_i does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high system reset (does not touch the power-off flag) |
| por_i | input | 1 | Power-on indication; sets the power-off flag |
| sfr_addr_i | input | 8 | Register bus address |
| sfr_wr_i | input | 1 | Register bus write strobe |
| sfr_wdata_i | input | 8 | Register bus write data |
| sfr_rdata_o | output | 8 | Register bus read data (0 for addresses not decoded) |
| tick_i | input | 1 | Single-cycle watchdog base tick |
| ee_busy_i | input | 1 | High while the EEPROM is programming |
| dp_sel_o | output | 1 | Data-pointer bank select |
| ee_en_o | output | 1 | Steer data-pointer accesses to on-chip EEPROM |
| ee_wr_en_o | output | 1 | EEPROM byte write enable |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The two functions that can land on the same clock edge are the software kick and the final tick of a watchdog period. To provoke this, the bench synchronises to a reset request and waits fourteen edges. It then issues the kick write so that the registered kick meets the sixteenth tick. It judges the result by counting edges until the next request: seventeen edges means the kick won and no request was raised at the collision. A second overlap checks that a kick write issued while programming is busy still reads back 0 in bit 1.

// File: rtl/wdmc_pkg.sv
package wdmc_pkg;

    localparam int DW         = 8;
    localparam int PS_W       = 3;
    localparam int BASE_TICKS = 16;

    // Bit positions inside the control byte
    localparam int BIT_WDEN   = 0;
    localparam int BIT_KICK   = 1;
    localparam int BIT_DPSEL  = 2;
    localparam int BIT_EEEN   = 3;
    localparam int BIT_EEWR   = 4;
    localparam int PS_LSB     = 5;

    // Power-control register: only this bit is implemented
    localparam int BIT_POF    = 4;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            ee_wr_en;
        logic            ee_en;
        logic            dp_sel;
        logic            wd_en;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [DW-1:0] d);
        ctrl_t c;
        c.ps       = d[PS_LSB +: PS_W];
        c.ee_wr_en = d[BIT_EEWR];
        c.ee_en    = d[BIT_EEEN];
        c.dp_sel   = d[BIT_DPSEL];
        c.wd_en    = d[BIT_WDEN];
        return c;
    endfunction

    function automatic logic [DW-1:0] pack_ctrl(input ctrl_t c, input logic ready);
        logic [DW-1:0] d;
        d                   = '0;
        d[PS_LSB +: PS_W]   = c.ps;
        d[BIT_EEWR]         = c.ee_wr_en;
        d[BIT_EEEN]         = c.ee_en;
        d[BIT_DPSEL]        = c.dp_sel;
        d[BIT_KICK]         = ready;
        d[BIT_WDEN]         = c.wd_en;
        return d;
    endfunction

endpackage

// File: rtl/wdmc_ctrl_reg.sv
module wdmc_ctrl_reg
    import wdmc_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          wr_hit_i,
    input  logic [DW-1:0] wdata_i,
    output ctrl_t         ctrl_o,
    output logic          kick_o,
    output logic          ps_chg_o
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_d;

    assign ctrl_d = unpack_ctrl(wdata_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q   <= '0;
            kick_o   <= 1'b0;
            ps_chg_o <= 1'b0;
        end else begin
            kick_o   <= wr_hit_i && wdata_i[BIT_KICK];
            ps_chg_o <= wr_hit_i && (ctrl_d.ps != ctrl_q.ps);
            if (wr_hit_i) begin
                ctrl_q <= ctrl_d;
            end
        end
    end

    assign ctrl_o = ctrl_q;

    // R8: a prescaler-change pulse only follows an actual change of the field
    p_ps_chg_real_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        ps_chg_o |-> (ctrl_q.ps != $past(ctrl_q.ps)));

    // R2: outside a write the stored routing bits stay put
    p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_hit_i |=> $stable(ctrl_q));

endmodule

// File: rtl/wdmc_wdt_count.sv
module wdmc_wdt_count #(
    parameter int BASE_TICKS = 16,
    parameter int PS_W       = 3
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            tick_i,
    input  logic            en_i,
    input  logic [PS_W-1:0] ps_i,
    input  logic            clr_i,
    output logic            expire_o
);

    localparam int MAX_PERIOD = BASE_TICKS << ((1 << PS_W) - 1);
    localparam int CNT_W      = $clog2(MAX_PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   period;
    logic             at_end;

    assign period = (CNT_W+1)'(BASE_TICKS) << ps_i;
    assign at_end = ({1'b0, cnt_q} >= (period - 1'b1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (clr_i || !en_i) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (at_end) begin
                    cnt_q    <= '0;
                    expire_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R4 / R9: a clear request empties the count and suppresses expiry
    p_clear_wins_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (cnt_q == '0) && !expire_o);

    // R7: disabled watchdog stays idle
    p_disabled_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (cnt_q == '0) && !expire_o);

    // R6: request lasts one cycle and coincides with a restarted count
    p_pulse_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        expire_o |=> !expire_o);
    p_pulse_restart_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        expire_o |-> (cnt_q == '0));

    // R5: count stays inside the selected period once settled
    p_cnt_in_range_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !clr_i |-> ({1'b0, cnt_q} < period));

endmodule

// File: rtl/wdmc_pof_flag.sv
module wdmc_pof_flag (
    input  logic clk_i,
    input  logic por_i,
    input  logic wr_i,
    input  logic bit_i,
    output logic flag_o
);

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            flag_o <= 1'b1;
        end else if (wr_i) begin
            flag_o <= bit_i;
        end
    end

    // R10: without power-on or a software write the flag holds
    p_pof_hold_r10: assert property (@(posedge clk_i) disable iff (por_i)
        !wr_i |=> $stable(flag_o));

endmodule

// File: rtl/wdt_memctl_sfr.sv
module wdt_memctl_sfr
    import wdmc_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h96,
    parameter logic [ADDR_W-1:0] PWR_ADDR  = 8'h87
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              por_i,
    input  logic [ADDR_W-1:0] sfr_addr_i,
    input  logic              sfr_wr_i,
    input  logic [DW-1:0]     sfr_wdata_i,
    output logic [DW-1:0]     sfr_rdata_o,
    input  logic              tick_i,
    input  logic              ee_busy_i,
    output logic              dp_sel_o,
    output logic              ee_en_o,
    output logic              ee_wr_en_o,
    output logic              wdt_rst_o
);

    logic  ctrl_hit;
    logic  pwr_hit;
    ctrl_t ctrl;
    logic  kick;
    logic  ps_chg;
    logic  pof;

    assign ctrl_hit = sfr_wr_i && (sfr_addr_i == CTRL_ADDR);
    assign pwr_hit  = sfr_wr_i && (sfr_addr_i == PWR_ADDR);

    wdmc_ctrl_reg u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wr_hit_i (ctrl_hit),
        .wdata_i  (sfr_wdata_i),
        .ctrl_o   (ctrl),
        .kick_o   (kick),
        .ps_chg_o (ps_chg)
    );

    wdmc_wdt_count #(
        .BASE_TICKS (BASE_TICKS),
        .PS_W       (PS_W)
    ) u_count (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick_i),
        .en_i     (ctrl.wd_en),
        .ps_i     (ctrl.ps),
        .clr_i    (kick || ps_chg),
        .expire_o (wdt_rst_o)
    );

    wdmc_pof_flag u_pof (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .wr_i   (pwr_hit),
        .bit_i  (sfr_wdata_i[BIT_POF]),
        .flag_o (pof)
    );

    always_comb begin
        sfr_rdata_o = '0;
        if (sfr_addr_i == CTRL_ADDR) begin
            sfr_rdata_o = pack_ctrl(ctrl, !ee_busy_i);
        end else if (sfr_addr_i == PWR_ADDR) begin
            sfr_rdata_o[BIT_POF] = pof;
        end
    end

    assign dp_sel_o   = ctrl.dp_sel;
    assign ee_en_o    = ctrl.ee_en;
    assign ee_wr_en_o = ctrl.ee_wr_en;

    // R3: busy programming always reads back as 0 at the kick position
    p_busy_reads_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ee_busy_i && sfr_addr_i == CTRL_ADDR) |-> !sfr_rdata_o[BIT_KICK]);

    // R2: a control write reaches the bank-select output on the next cycle
    p_dpsel_follows_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_hit |=> (dp_sel_o == $past(sfr_wdata_i[BIT_DPSEL])));

endmodule

// File: tb/test_wdt_memctl_sfr.sv
module test_wdt_memctl_sfr;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       por_i = 1'b1;
    logic [7:0] sfr_addr_i = 8'h00;
    logic       sfr_wr_i = 1'b0;
    logic [7:0] sfr_wdata_i = 8'h00;
    logic [7:0] sfr_rdata_o;
    logic       tick_i = 1'b0;
    logic       ee_busy_i = 1'b0;
    logic       dp_sel_o, ee_en_o, ee_wr_en_o, wdt_rst_o;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [7:0] A_CTRL = 8'h96;
    localparam logic [7:0] A_PWR  = 8'h87;

    always #2 clk_i = ~clk_i;

    wdt_memctl_sfr i_wdt_memctl_sfr (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .por_i       (por_i),
        .sfr_addr_i  (sfr_addr_i),
        .sfr_wr_i    (sfr_wr_i),
        .sfr_wdata_i (sfr_wdata_i),
        .sfr_rdata_o (sfr_rdata_o),
        .tick_i      (tick_i),
        .ee_busy_i   (ee_busy_i),
        .dp_sel_o    (dp_sel_o),
        .ee_en_o     (ee_en_o),
        .ee_wr_en_o  (ee_wr_en_o),
        .wdt_rst_o   (wdt_rst_o)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, actual, expected);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk_i);
        sfr_addr_i  = a;
        sfr_wdata_i = d;
        sfr_wr_i    = 1'b1;
        @(posedge clk_i);
        #1;
        sfr_wr_i    = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk_i);
        sfr_addr_i = a;
        #1;
        d = sfr_rdata_o;
    endtask

    // Count clock edges until the reset request shows, limit bounds the wait
    task automatic edges_to_pulse(input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk_i);
            #1;
            n++;
        end while (!wdt_rst_o && n < limit);
    endtask

    task automatic sys_reset();
        @(negedge clk_i);
        rst_i = 1'b1;
        repeat (2) @(posedge clk_i);
        @(negedge clk_i);
        rst_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        sfr_read(A_CTRL, d);
        check("R1 control reset value", d, 8'h02);
        check("R1 routing outputs", {dp_sel_o, ee_en_o, ee_wr_en_o}, 0);
        check("R1 no reset request", wdt_rst_o, 0);
    endtask

    task automatic t_ctrl_bits();
        logic [7:0] d;
        sfr_write(A_CTRL, 8'h1C);
        check("R2 outputs set", {ee_wr_en_o, ee_en_o, dp_sel_o}, 3'b111);
        sfr_read(A_CTRL, d);
        check("R2 readback", d, 8'h1E);
        sfr_write(8'h95, 8'h00);
        check("R2 other address ignored", {ee_wr_en_o, ee_en_o, dp_sel_o}, 3'b111);
        sfr_write(A_CTRL, 8'h08);
        check("R2 partial pattern", {ee_wr_en_o, ee_en_o, dp_sel_o}, 3'b010);
        sfr_write(A_CTRL, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] d;
        ee_busy_i = 1'b1;
        sfr_read(A_CTRL, d);
        check("R3 busy reads 0", d, 8'h00);
        sfr_write(A_CTRL, 8'h02);
        sfr_read(A_CTRL, d);
        check("R3 kick while busy not stored", d, 8'h00);
        ee_busy_i = 1'b0;
        sfr_read(A_CTRL, d);
        check("R3 ready reads 1", d, 8'h02);
    endtask

    task automatic t_period();
        int n;
        tick_i = 1'b1;
        sfr_write(A_CTRL, 8'h01);
        edges_to_pulse(5000, n);
        check("R5 period ps=0", n, 16);
        edges_to_pulse(5000, n);
        check("R6 single pulse then full period", n, 16);
        sfr_write(A_CTRL, 8'hE1);
        edges_to_pulse(5000, n);
        check("R8 change to ps=7 clears count", n, 2049);
        sfr_write(A_CTRL, 8'h21);
        edges_to_pulse(5000, n);
        check("R8 change to ps=1 clears count", n, 33);
        sfr_write(A_CTRL, 8'h01);
        edges_to_pulse(5000, n);
        check("R8 back to ps=0", n, 17);
    endtask

    task automatic t_kick();
        int n;
        repeat (5) @(posedge clk_i);
        sfr_write(A_CTRL, 8'h03);
        edges_to_pulse(5000, n);
        check("R4 kick restarts count", n, 17);
    endtask

    task automatic t_coincide();
        int n;
        repeat (14) @(posedge clk_i);
        sfr_write(A_CTRL, 8'h03);
        edges_to_pulse(5000, n);
        check("R9 kick beats final tick", n, 17);
    endtask

    task automatic t_disable();
        int n;
        int pulses;
        repeat (10) @(posedge clk_i);
        sfr_write(A_CTRL, 8'h00);
        pulses = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk_i);
            #1;
            if (wdt_rst_o) pulses++;
        end
        check("R7 no request while disabled", pulses, 0);
        sfr_write(A_CTRL, 8'h01);
        edges_to_pulse(5000, n);
        check("R7 fresh count after enable", n, 16);
        @(negedge clk_i);
        tick_i = 1'b0;
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk_i);
            #1;
            if (wdt_rst_o) pulses++;
        end
        check("R5 no count without ticks", pulses, 0);
        @(negedge clk_i);
        tick_i = 1'b1;
        edges_to_pulse(5000, n);
        check("R5 count resumes on ticks", n, 16);
        sfr_write(A_CTRL, 8'h00);
    endtask

    task automatic t_pof();
        logic [7:0] d;
        sfr_read(A_PWR, d);
        check("R10 set by power-on", d, 8'h10);
        sfr_write(A_PWR, 8'h00);
        sfr_read(A_PWR, d);
        check("R10 software clear", d, 8'h00);
        sys_reset();
        sfr_read(A_PWR, d);
        check("R10 clear survives reset", d, 8'h00);
        sfr_write(A_PWR, 8'hFF);
        sfr_read(A_PWR, d);
        check("R10 software set, other bits 0", d, 8'h10);
        sys_reset();
        sfr_read(A_PWR, d);
        check("R10 set survives reset", d, 8'h10);
        sfr_read(A_CTRL, d);
        check("R1 control reset after reset", d, 8'h02);
    endtask

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        por_i = 1'b0;
        rst_i = 1'b0;
        t_reset();
        t_ctrl_bits();
        t_busy();
        t_period();
        t_kick();
        t_coincide();
        t_disable();
        t_pof();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule